// File: doc/BRIEF.md
# UART Interrupt Priority Identification Unit

This block turns the interrupt sources of a 16550-style serial port into the identification byte that software reads and the single interrupt line that goes to the interrupt controller. It takes the four interrupt-enable bits, the receiver error flags, the data-ready flag, the receive FIFO fill count and trigger level, the character-timeout pending flag, the holding-register empty status and the modem-status change bits. From these it picks the most urgent enabled source and registers its code.

The transmit-empty source is not a plain level. The block keeps a sticky pending flag for it. The flag is armed when the holding register becomes empty or when its enable bit is raised while the register is already empty. It is dropped when software reads the identification byte while that byte shows the transmit-empty code, when the holding register is written, or when the enable bit is cleared. Serial shifting, the FIFO storage and baud generation are handled by neighbouring blocks.

Top module: `irq_ident_unit`

## Requirements
- R1: After reset `iid_out` reads 0x01, `irq` is low and the transmit-empty pending flag is clear.
- R2: With `ier_bits[2]` set and any `line_err` bit set, the code in `iid_out[3:0]` is 0x6, ahead of every other source.
- R3: With `rx_timeout` set and `ier_bits[0]` set, and no line-status source, the code is 0xC; with `ier_bits[0]` clear the timeout is never reported.
- R4: With `ier_bits[0]` and `data_ready` set, and no higher source, the code is 0x4 when `fifo_on` is low, or when `fifo_on` is high and `rx_count >= rx_level`; with `fifo_on` high and the count below the level this source is inactive.
- R5: With `ier_bits[1]` set and the transmit-empty pending flag set, and no higher source, the code is 0x2.
- R6: With `ier_bits[3]` set and any `msr_delta` bit set, and no higher source, the code is 0x0.
- R7: With no enabled active source the code is 0x1.
- R8: `iid_out[7:6]` is 11 when `fifo_on` is high and 00 otherwise; `iid_out[5:4]` is always 00.
- R9: `irq` is high exactly when `iid_out[3:0]` is not 0x1.
- R10: A cycle with `id_read` high while `iid_out[3:0]` is 0x2 clears the transmit-empty pending flag; a read while another code is shown leaves it unchanged.
- R11: A 0-to-1 change of `ier_bits[1]` while `thr_empty` is high arms the pending flag; `ier_bits[1]` low keeps the flag clear.
- R12: `thr_write` high clears the pending flag (it wins over an arming event in the same cycle); a later 0-to-1 change of `thr_empty` with `ier_bits[1]` set arms it again. The empty-status history resets to "empty".
- R13: `iid_out` and `irq` reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_bits | input | 4 | Enables: bit0 receive data/timeout, bit1 transmit empty, bit2 line status, bit3 modem status |
| line_err | input | ERR_W | Receiver error flags (overrun, parity, framing, break) |
| data_ready | input | 1 | Receive data available |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_level | input | CNT_W | Receive FIFO trigger level in entries |
| fifo_on | input | 1 | FIFO mode enabled |
| rx_timeout | input | 1 | Character timeout pending |
| thr_empty | input | 1 | Holding register empty status |
| thr_write | input | 1 | One-cycle pulse: holding register written |
| id_read | input | 1 | One-cycle pulse: identification byte read |
| msr_delta | input | DELTA_W | Modem-status change bits |
| iid_out | output | 8 | Registered identification byte |
| irq | output | 1 | Registered interrupt request |

## Verification
Every result of this block is due exactly one clock after the edge that samples the stimulus: the identification byte, the interrupt line and the effect of a read, a write or an enable edge on the pending flag all appear together. The bench drives inputs on the falling edge, lets one rising edge pass and compares on the following falling edge, so each comparison sees the value produced by that single edge. Pending-flag effects are observed through the code they produce one cycle later, including the case where a read of a higher-priority code must leave the flag intact.

// File: rtl/irqid_pkg.sv
package irqid_pkg;

   typedef enum logic [3:0] {
      ID_MODEM = 4'h0,
      ID_NONE  = 4'h1,
      ID_TXE   = 4'h2,
      ID_RXD   = 4'h4,
      ID_LINE  = 4'h6,
      ID_TMO   = 4'hC
   } id_code_e;

   // source slots in descending urgency
   localparam int SRC_LINE  = 0;
   localparam int SRC_TMO   = 1;
   localparam int SRC_RXD   = 2;
   localparam int SRC_TXE   = 3;
   localparam int SRC_MODEM = 4;
   localparam int NUM_SRC   = 5;

   function automatic id_code_e src_code(input int idx);
      case (idx)
         SRC_LINE:  return ID_LINE;
         SRC_TMO:   return ID_TMO;
         SRC_RXD:   return ID_RXD;
         SRC_TXE:   return ID_TXE;
         default:   return ID_MODEM;
      endcase
   endfunction

endpackage

// File: rtl/irqid_tx_pend.sv
module irqid_tx_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic thr_empty,
   input  logic thr_write,
   input  logic id_read,
   input  logic shows_txe,
   output logic pend_d,
   output logic pend_q
);
   logic en_q;
   logic empty_q;
   logic arm;

   assign arm = (tx_en && !en_q && thr_empty) || (thr_empty && !empty_q);

   always_comb begin
      pend_d = pend_q;
      if (!tx_en)
         pend_d = 1'b0;
      else if (thr_write)
         pend_d = 1'b0;
      else if (arm)
         pend_d = 1'b1;
      else if (id_read && shows_txe)
         pend_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         en_q    <= 1'b0;
         empty_q <= 1'b1;
      end else begin
         pend_q  <= pend_d;
         en_q    <= tx_en;
         empty_q <= thr_empty;
      end
   end
endmodule

// File: rtl/irqid_rx_qual.sv
module irqid_rx_qual #(
   parameter int CNT_W = 5
) (
   input  logic             data_ready,
   input  logic             fifo_on,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] rx_level,
   output logic             rx_ok
);
   logic at_level;
   assign at_level = (rx_count >= rx_level);
   assign rx_ok    = data_ready && (!fifo_on || at_level);
endmodule

// File: rtl/irqid_prio_enc.sv
module irqid_prio_enc
   import irqid_pkg::*;
#(
   parameter int N = NUM_SRC
) (
   input  logic [N-1:0] req,
   output id_code_e     code
);
   logic [N-1:0] win;
   logic [N:0]   taken;

   assign taken[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_chain
         assign win[i]     = req[i] && !taken[i];
         assign taken[i+1] = taken[i] || req[i];
      end
   endgenerate

   always_comb begin
      code = ID_NONE;
      for (int i = 0; i < N; i++) begin
         if (win[i]) code = src_code(i);
      end
   end
endmodule

// File: rtl/irq_ident_unit.sv
module irq_ident_unit
   import irqid_pkg::*;
#(
   parameter int CNT_W   = 5,
   parameter int ERR_W   = 4,
   parameter int DELTA_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         ier_bits,
   input  logic [ERR_W-1:0]   line_err,
   input  logic               data_ready,
   input  logic [CNT_W-1:0]   rx_count,
   input  logic [CNT_W-1:0]   rx_level,
   input  logic               fifo_on,
   input  logic               rx_timeout,
   input  logic               thr_empty,
   input  logic               thr_write,
   input  logic               id_read,
   input  logic [DELTA_W-1:0] msr_delta,
   output logic [7:0]         iid_out,
   output logic               irq
);
   localparam logic [7:0] IID_RESET = {4'h0, ID_NONE};

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (ERR_W < 1 || DELTA_W < 1) begin : g_bad_w
         $error("flag widths must be positive");
      end
      if (NUM_SRC != 5) begin : g_bad_src
         $error("source table mismatch");
      end
   endgenerate

   logic [NUM_SRC-1:0] req;
   logic               rx_ok;
   logic               pend_d;
   logic               pend_q;
   logic               shows_txe;
   id_code_e           code;
   logic [7:0]         iid_q;
   logic               irq_q;

   assign shows_txe = (iid_q[3:0] == ID_TXE);

   irqid_tx_pend u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (ier_bits[1]),
      .thr_empty (thr_empty),
      .thr_write (thr_write),
      .id_read   (id_read),
      .shows_txe (shows_txe),
      .pend_d    (pend_d),
      .pend_q    (pend_q)
   );

   irqid_rx_qual #(.CNT_W(CNT_W)) u_rxq (
      .data_ready (data_ready),
      .fifo_on    (fifo_on),
      .rx_count   (rx_count),
      .rx_level   (rx_level),
      .rx_ok      (rx_ok)
   );

   assign req[SRC_LINE]  = ier_bits[2] && (|line_err);
   assign req[SRC_TMO]   = ier_bits[0] && rx_timeout;
   assign req[SRC_RXD]   = ier_bits[0] && rx_ok;
   assign req[SRC_TXE]   = ier_bits[1] && pend_d;
   assign req[SRC_MODEM] = ier_bits[3] && (|msr_delta);

   irqid_prio_enc #(.N(NUM_SRC)) u_enc (
      .req  (req),
      .code (code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iid_q <= IID_RESET;
         irq_q <= 1'b0;
      end else begin
         iid_q <= {{2{fifo_on}}, 2'b00, code};
         irq_q <= (code != ID_NONE);
      end
   end

   assign iid_out = iid_q;
   assign irq     = irq_q;

   logic unused_pend;
   assign unused_pend = pend_q;
endmodule

// File: rtl/irq_ident_checker.sv
module irq_ident_checker #(
   parameter int ERR_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       ier_bits,
   input logic [ERR_W-1:0] line_err,
   input logic             fifo_on,
   input logic             thr_write,
   input logic [7:0]       iid_out,
   input logic             irq
);
   assert_line_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_bits[2] && |line_err) |=> (iid_out[3:0] == 4'h6));

   assert_timeout_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ier_bits[0] |=> (iid_out[3:0] != 4'hC));

   assert_fifo_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_on |=> (iid_out[7:4] == 4'hC));

   assert_irq_tracks_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (iid_out[3:0] != 4'h1));

   assert_txe_off_when_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !ier_bits[1] |=> (iid_out[3:0] != 4'h2));

   assert_write_drops_txe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      thr_write |=> (iid_out[3:0] != 4'h2));
endmodule

bind irq_ident_unit irq_ident_checker #(.ERR_W(ERR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ier_bits  (ier_bits),
   .line_err  (line_err),
   .fifo_on   (fifo_on),
   .thr_write (thr_write),
   .iid_out   (iid_out),
   .irq       (irq)
);

// File: tb/irq_ident_unit_bench.sv
module irq_ident_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    ier_bits = '0;
   logic [3:0]    line_err = '0;
   logic          data_ready = 1'b0;
   logic [CW-1:0] rx_count = '0;
   logic [CW-1:0] rx_level = '0;
   logic          fifo_on = 1'b0;
   logic          rx_timeout = 1'b0;
   logic          thr_empty = 1'b0;
   logic          thr_write = 1'b0;
   logic          id_read = 1'b0;
   logic [3:0]    msr_delta = '0;
   logic [7:0]    iid_out;
   logic          irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   // bench reference state
   bit       m_pend, m_en_q, m_empty_q;
   bit [7:0] m_iid;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_ident_unit #(.CNT_W(CW), .ERR_W(4), .DELTA_W(4)) u_irq_ident_unit (
      .clk(clk), .rst_n(rst_n), .ier_bits(ier_bits), .line_err(line_err),
      .data_ready(data_ready), .rx_count(rx_count), .rx_level(rx_level),
      .fifo_on(fifo_on), .rx_timeout(rx_timeout), .thr_empty(thr_empty),
      .thr_write(thr_write), .id_read(id_read), .msr_delta(msr_delta),
      .iid_out(iid_out), .irq(irq)
   );

   task automatic check(input string tag, input logic [7:0] exp_iid);
      logic exp_irq;
      exp_irq = (exp_iid[3:0] != 4'h1);
      n_run++;
      if (iid_out !== exp_iid || irq !== exp_irq) begin
         n_fail++;
         $display("FAIL %s: iid=%02h irq=%b expected iid=%02h irq=%b",
                  tag, iid_out, irq, exp_iid, exp_irq);
      end
   endtask

   // inputs are set at a falling edge; one rising edge later, compare
   task automatic step(input string tag, input logic [7:0] exp_iid);
      @(posedge clk);
      @(negedge clk);
      check(tag, exp_iid);
      thr_write = 1'b0;
      id_read = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ier_bits = '0; line_err = '0; data_ready = 0; rx_count = '0;
      rx_level = '0; fifo_on = 0; rx_timeout = 0; thr_empty = 0;
      thr_write = 0; id_read = 0; msr_delta = '0;
      m_pend = 0; m_en_q = 0; m_empty_q = 1; m_iid = 8'h01;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic string tag_for(input logic [3:0] c);
      case (c)
         4'h6: return "R2";
         4'hC: return "R3";
         4'h4: return "R4";
         4'h2: return "R5";
         4'h0: return "R6";
         default: return "R7";
      endcase
   endfunction

   // reference update for one rising edge, from the requirement text
   function automatic void model_edge();
      bit arm, pn, rx_ok;
      logic [3:0] c;
      arm = (ier_bits[1] && !m_en_q && thr_empty) || (thr_empty && !m_empty_q);
      pn = m_pend;
      if (!ier_bits[1]) pn = 0;
      else if (thr_write) pn = 0;
      else if (arm) pn = 1;
      else if (id_read && m_iid[3:0] == 4'h2) pn = 0;
      rx_ok = data_ready && (!fifo_on || rx_count >= rx_level);
      if (ier_bits[2] && |line_err)        c = 4'h6;
      else if (ier_bits[0] && rx_timeout)  c = 4'hC;
      else if (ier_bits[0] && rx_ok)       c = 4'h4;
      else if (ier_bits[1] && pn)          c = 4'h2;
      else if (ier_bits[3] && |msr_delta)  c = 4'h0;
      else                                 c = 4'h1;
      m_pend = pn;
      m_en_q = ier_bits[1];
      m_empty_q = thr_empty;
      m_iid = {{2{fifo_on}}, 2'b00, c};
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      do_reset();
      check("R1 reset state", 8'h01);

      // R7 idle
      step("R7 no source", 8'h01);

      // R11 enable rise with empty holding register arms; R5 code
      ier_bits = 4'b0010; thr_empty = 1;
      step("R11 arm on enable rise", 8'h02);
      step("R5 pending holds", 8'h02);

      // R10 read while showing 0x2 clears
      id_read = 1;
      step("R10 read clears txe", 8'h01);

      // R12 write clears, next empty rise re-arms
      thr_write = 1; thr_empty = 0;
      step("R12 write clears", 8'h01);
      thr_empty = 1;
      step("R12 empty rise re-arms", 8'h02);

      // R11 enable drop clears, raise again re-arms
      ier_bits = 4'b0000;
      step("R11 disable clears", 8'h01);
      ier_bits = 4'b0110;
      step("R11 re-arm", 8'h02);

      // R2 line status wins; R10 read of another code keeps pending
      line_err = 4'b0100;
      step("R2 line status", 8'h06);
      id_read = 1;
      step("R10 read of other code", 8'h06);
      line_err = '0;
      step("R10 pending survived", 8'h02);

      // R3 timeout masked, then shown
      rx_timeout = 1; ier_bits = 4'b0010;
      step("R3 timeout masked", 8'h02);
      ier_bits = 4'b0011;
      step("R3 timeout shown", 8'h0C);

      // R4 / R8 FIFO trigger level
      rx_timeout = 0; ier_bits = 4'b0001; fifo_on = 1;
      data_ready = 1; rx_count = 5'd3; rx_level = 5'd4;
      step("R4 below level R8", 8'hC1);
      rx_count = 5'd4;
      step("R4 at level R8", 8'hC4);
      fifo_on = 0; rx_count = 5'd0;
      step("R4 non-fifo data ready", 8'h04);

      // R6 modem status, code 0x0 still raises irq (R9)
      data_ready = 0; ier_bits = 4'b1000; msr_delta = 4'b0010;
      step("R6 modem R9", 8'h00);
      ier_bits = 4'b0000;
      step("R6 modem masked", 8'h01);

      // R13 constrained random against the reference
      do_reset();
      for (int k = 0; k < 3000; k++) begin
         logic [7:0] exp;
         ier_bits   = 4'($urandom);
         line_err   = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
         data_ready = 1'($urandom);
         rx_count   = CW'($urandom % 17);
         rx_level   = ($urandom % 2) ? 5'd1 : CW'(($urandom % 4) * 4);
         fifo_on    = ($urandom % 4 != 0);
         rx_timeout = ($urandom % 5 == 0);
         msr_delta  = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
         thr_write  = ($urandom % 6 == 0);
         id_read    = ($urandom % 3 == 0);
         if (thr_write) thr_empty = 0;
         else if (!thr_empty) thr_empty = ($urandom % 3 == 0);
         model_edge();
         exp = m_iid;
         step($sformatf("R13 %s random #%0d", tag_for(exp[3:0]), k), exp);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule